// File: doc/BRIEF.md
# Binary-Field Word-Serial Montgomery Multiplier

This block multiplies two polynomials over GF(2) in Montgomery form. It returns c(x) = a(x)·b(x)·x^(-32M) mod f(x), where M is the number of 32-bit words in use (1 to 8), so operands can be up to 256 bits. The caller supplies a, b, the modulus f, the word count and the word constant N0 = F0^-1 mod x^32, where F0 is the lowest word of f. All of these are captured on a one-cycle start strobe. After a fixed number of cycles the block presents c together with a one-cycle done pulse.

Each pass consumes one word A_j of a, starting from the lowest. The pass adds A_j·b into a 288-bit accumulator. It then forms the quotient word q = C0·N0 mod x^32 from the lowest accumulator word C0, adds q·f, and shifts the accumulator right by one word. All additions are XOR. A single 32×257 carry-less multiplier serves both the a-word product and the q-word product. A small 32×32 carry-less multiplier forms the quotient.

Top module: `gf2_mont_mul`

## Requirements
- R1: While reset is held and after its release, done_o is 0 and c_o is all zero until the first operation completes.
- R2: When f has constant term 1, deg f ≤ 32M, deg b < deg f and N0·F0 ≡ 1 mod x^32, the result c_o equals a·b·x^(-32M) mod f with deg c_o < deg f. This includes the field f = x^191 + x^9 + 1 with M = 6.
- R3: Only the lowest M words of a_i (bits 32M−1..0) affect the result. The bits of a_i above them are ignored.
- R4: done_o is a single-cycle pulse. It is high in the cycle after the 4M-th rising edge that follows the edge on which start_i was sampled high in idle.
- R5: A start_i pulse while an operation is running is ignored. So are changes to the operand inputs while an operation is running. The running result and its timing are unchanged.
- R6: c_o keeps its value between completions. It only changes in the cycle in which done_o is high.
- R7: words_i is the word count M, encoded as an unsigned binary value from 1 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Captures operands and starts an operation when idle |
| a_i | input | 256 | Multiplier polynomial a, bit i is the coefficient of x^i |
| b_i | input | 256 | Multiplicand polynomial b |
| f_i | input | 257 | Modulus polynomial f, bit 256 is the coefficient of x^256 |
| words_i | input | 4 | Word count M, 1 to 8 |
| n0_i | input | 32 | Constant N0 with N0·F0 ≡ 1 mod x^32 |
| c_o | output | 256 | Result a·b·x^(-32M) mod f |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every operation runs four cycles per word: multiply, quotient, reduce, shift. The result and done_o are therefore due exactly 4M edges after the start edge. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the start strobe and expects done_o on count 4M+1, then expects it low on the next one. The bench reads c_o on the done cycle and compares it with a bit-serial reference reduction computed in the bench, for every M from 1 to 8 and for many operands in the 191-bit field. It also checks that c_o is unchanged one cycle after done, and that a start strobe issued mid-operation leaves the first result intact.

// File: rtl/gf2_mont_pkg.sv
package gf2_mont_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_MUL   = 3'd1,
    ST_QUOT  = 3'd2,
    ST_RED   = 3'd3,
    ST_SHIFT = 3'd4
  } mont_state_e;
endpackage

// File: rtl/gf2_clmul.sv
// Carry-less product, truncated to P_W bits (P_W >= B_W).
module gf2_clmul #(
  parameter int unsigned A_W = 32,
  parameter int unsigned B_W = 32,
  parameter int unsigned P_W = 32
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [P_W-1:0] p_o
);
  logic [P_W-1:0] b_ext;
  logic [P_W-1:0] pp [A_W+1];

  assign b_ext = P_W'(b_i);
  assign pp[0] = '0;

  for (genvar i = 0; i < A_W; i++) begin : g_row
    assign pp[i+1] = pp[i] ^ (a_i[i] ? (b_ext << i) : '0);
  end

  assign p_o = pp[A_W];
endmodule

// File: rtl/gf2_mont_ctrl.sv
module gf2_mont_ctrl
  import gf2_mont_pkg::*;
#(
  parameter int unsigned MAX_WORDS = 8,
  localparam int unsigned CNT_W = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] words_i,
  output mont_state_e      state_o,
  output logic             load_o,
  output logic             last_o
);
  mont_state_e      state_q;
  logic [CNT_W-1:0] iter_q;
  logic [CNT_W-1:0] words_q;

  assign state_o = state_q;
  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign last_o  = (state_q == ST_SHIFT) && (iter_q == words_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      words_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          words_q <= words_i;
          iter_q  <= '0;
          state_q <= ST_MUL;
        end
        ST_MUL:  state_q <= ST_QUOT;
        ST_QUOT: state_q <= ST_RED;
        ST_RED:  state_q <= ST_SHIFT;
        ST_SHIFT: begin
          if (last_o) state_q <= ST_IDLE;
          else begin
            iter_q  <= iter_q + CNT_W'(1);
            state_q <= ST_MUL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: word count frozen while busy
  a_r5_words_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(words_q));
  // R7: iteration index stays inside the programmed word count
  a_r7_iter_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (iter_q < words_q));
endmodule

// File: rtl/gf2_mont_mul.sv
module gf2_mont_mul
  import gf2_mont_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned MAX_WORDS = 8,
  localparam int unsigned VEC_W = WORD_W * MAX_WORDS,
  localparam int unsigned ACC_W = VEC_W + WORD_W,
  localparam int unsigned CNT_W = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic [VEC_W:0]   f_i,
  input  logic [CNT_W-1:0] words_i,
  input  logic [WORD_W-1:0] n0_i,
  output logic [VEC_W-1:0] c_o,
  output logic             done_o
);
  mont_state_e state;
  logic        load, last;

  logic [VEC_W-1:0]  a_q, b_q, c_q;
  logic [VEC_W:0]    f_q;
  logic [WORD_W-1:0] n0_q, q_q;
  logic [ACC_W-1:0]  acc_q;
  logic              done_q;

  logic [WORD_W-1:0] mul_word, q_next;
  logic [VEC_W:0]    mul_vec;
  logic [ACC_W-1:0]  prod;
  logic [VEC_W-1:0]  acc_sh;

  gf2_mont_ctrl #(.MAX_WORDS(MAX_WORDS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .words_i (words_i),
    .state_o (state),
    .load_o  (load),
    .last_o  (last)
  );

  // Shared wide multiplier: a word times b, or quotient times f
  assign mul_word = (state == ST_RED) ? q_q : a_q[WORD_W-1:0];
  assign mul_vec  = (state == ST_RED) ? f_q : {1'b0, b_q};

  gf2_clmul #(.A_W(WORD_W), .B_W(VEC_W + 1), .P_W(ACC_W)) u_wide (
    .a_i (mul_word),
    .b_i (mul_vec),
    .p_o (prod)
  );

  gf2_clmul #(.A_W(WORD_W), .B_W(WORD_W), .P_W(WORD_W)) u_quot (
    .a_i (acc_q[WORD_W-1:0]),
    .b_i (n0_q),
    .p_o (q_next)
  );

  assign acc_sh = acc_q[ACC_W-1:WORD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      f_q    <= '0;
      n0_q   <= '0;
      q_q    <= '0;
      acc_q  <= '0;
      c_q    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        a_q   <= a_i;
        b_q   <= b_i;
        f_q   <= f_i;
        n0_q  <= n0_i;
        acc_q <= '0;
      end
      unique case (state)
        ST_MUL:  acc_q <= acc_q ^ prod;
        ST_QUOT: q_q   <= q_next;
        ST_RED:  acc_q <= acc_q ^ prod;
        ST_SHIFT: begin
          acc_q <= ACC_W'(acc_sh);
          a_q   <= a_q >> WORD_W;
          if (last) begin
            c_q    <= acc_sh;
            done_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign c_o    = c_q;
  assign done_o = done_q;

  // R2: the reduction step must clear the lowest accumulator word
  a_r2_low_word_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SHIFT) |-> (acc_q[WORD_W-1:0] == '0));
  // R4: done is a single pulse
  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4: done only follows a shift step
  a_r4_done_after_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state == ST_SHIFT));
  // R6: result held between completions
  a_r6_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(c_o));
endmodule

// File: tb/gf2_mont_mul_test.sv
`timescale 1ns/1ps
module gf2_mont_mul_test;
  localparam int W = 32;
  localparam int V = 256;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [V-1:0]   a = '0, b = '0;
  logic [V:0]     f = '0;
  logic [3:0]     words = 4'd1;
  logic [W-1:0]   n0 = '0;
  logic [V-1:0]   c;
  logic           done;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  gf2_mont_mul uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a), .b_i(b), .f_i(f), .words_i(words), .n0_i(n0),
    .c_o(c), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [V-1:0] act, input logic [V-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] clmul_lo(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) if (x[i]) r ^= (y << i);
    return r;
  endfunction

  function automatic logic [W-1:0] inv_word(input logic [W-1:0] f0);
    logic [W-1:0] n = 32'd1;
    for (int k = 1; k < W; k++) begin
      logic [W-1:0] t = clmul_lo(n, f0);
      if (t[k]) n[k] = 1'b1;
    end
    return n;
  endfunction

  // Bit-serial reduction: one bit of a per step
  function automatic logic [V-1:0] ref_mont(input logic [V-1:0] x, input logic [V-1:0] y,
                                            input logic [V:0] m, input int nw);
    logic [V+1:0] r = '0;
    for (int i = 0; i < 32 * nw; i++) begin
      if (x[i]) r ^= {2'b00, y};
      if (r[0]) r ^= {1'b0, m};
      r = r >> 1;
    end
    return r[V-1:0];
  endfunction

  function automatic logic [V-1:0] rand_vec();
    logic [V-1:0] r;
    for (int i = 0; i < V / W; i++) r[i*W +: W] = $urandom;
    return r;
  endfunction

  function automatic logic [V:0] low_mask(input int deg);
    return ({{V{1'b0}}, 1'b1} << deg) - 1;
  endfunction

  // Runs one operation; busy_poke injects a second start mid-run
  task automatic run_op(input logic [V-1:0] ta, input logic [V-1:0] tb,
                        input logic [V:0] tf, input int nw, input bit busy_poke,
                        input string tag);
    int cnt = 0;
    logic [V-1:0] exp_c, got;
    exp_c = ref_mont(ta, tb, tf, nw);
    @(negedge clk);
    a = ta; b = tb; f = tf; words = 4'(nw); n0 = inv_word(tf[W-1:0]);
    start = 1'b1;
    forever begin
      @(negedge clk);
      if (cnt == 0) start = 1'b0;
      cnt++;
      if (busy_poke && cnt == 3) begin
        start = 1'b1; a = ~ta; b = '0; words = 4'd1; n0 = ~n0;
      end
      if (busy_poke && cnt == 4) start = 1'b0;
      if (done || cnt > 200) break;
    end
    got = c;
    check(done, "R4", {tag, " done seen"}, V'(cnt), V'(4 * nw + 1));
    check(cnt == 4 * nw + 1, "R4", {tag, " latency"}, V'(cnt), V'(4 * nw + 1));
    check(got == exp_c, busy_poke ? "R5" : "R2", {tag, " result"}, got, exp_c);
    @(negedge clk);
    check(!done, "R4", {tag, " single pulse"}, V'(done), '0);
    check(c == got, "R6", {tag, " hold"}, c, got);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [V:0]   f191;
    logic [V-1:0] va, vb;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", "done in reset", V'(done), '0);
    check(c == '0, "R1", "c in reset", c, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && c == '0, "R1", "idle after reset", c, '0);

    // R7: word count sweep 1..8 with random moduli of top degree
    for (int nw = 1; nw <= 8; nw++) begin
      for (int k = 0; k < 5; k++) begin
        int deg = 32 * nw - int'($urandom % 32);
        logic [V:0] tf = ({1'b0, rand_vec()} & low_mask(deg)) | ({{V{1'b0}}, 1'b1} << deg) | 1;
        // R3: upper words of a left random
        run_op(rand_vec(), rand_vec() & low_mask(deg)[V-1:0], tf, nw, 1'b0, "sweep R7");
      end
    end

    f191 = ({{V{1'b0}}, 1'b1} << 191) | ({{V{1'b0}}, 1'b1} << 9) | 1;
    // R2 corners in the 191-bit field
    run_op('0, rand_vec() & low_mask(191)[V-1:0], f191, 6, 1'b0, "a zero R2");
    run_op(rand_vec(), '0, f191, 6, 1'b0, "b zero R2");
    run_op(V'(1), V'(1), f191, 6, 1'b0, "unit R2");
    run_op(low_mask(192)[V-1:0], low_mask(191)[V-1:0], f191, 6, 1'b0, "all ones R2");
    for (int k = 0; k < 16; k++)
      run_op(rand_vec() & low_mask(192)[V-1:0], rand_vec() & low_mask(191)[V-1:0],
             f191, 6, 1'b0, "field191 R2");

    // R3: garbage above word M gives the same result as a clean a
    va = rand_vec(); vb = rand_vec() & low_mask(191)[V-1:0];
    run_op(va | ~low_mask(192)[V-1:0], vb, f191, 6, 1'b0, "upper a ignored R3");
    check(c == ref_mont(va & low_mask(192)[V-1:0], vb, f191, 6), "R3", "clean a match",
          c, ref_mont(va & low_mask(192)[V-1:0], vb, f191, 6));

    // R5: start while busy ignored
    run_op(rand_vec(), rand_vec() & low_mask(191)[V-1:0], f191, 6, 1'b1, "busy start R5");
    run_op(rand_vec(), rand_vec() & low_mask(63)[V-1:0],
           ({{V{1'b0}}, 1'b1} << 63) | 33'h1_0000_0003, 2, 1'b1, "busy short R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule